// File: doc/BRIEF.md
# Scan Ring Rotation Test Sequencer

This block checks scan-chain integrity in the middle of normal operation, with no loss of functional state. It holds a small register file whose entries are joined into a closed shift ring. When the surrounding logic raises a start request while the block is running normally, the block works through a fixed sequence. It freezes functional updates and keeps a copy of the mode register. It forces scan mode, with the tail of the chain wired back to its head. It then shifts once for every entry in the ring, puts the saved mode back and lets functional updates run again.

A full rotation carries every entry once round the loop and back to where it started, so a healthy ring ends bit-identical to the way it began. A wrong-count request shortens the rotation by a fixed offset. On a ring whose contents are not rotation-invariant, that must leave the contents visibly changed, which proves the test really moves data. A monitor watches the ring tail during shifting and counts value changes. When the sequence ends, a one-cycle done pulse reports whether the ring contents matched the copy taken before shifting, and whether the monitor saw a frozen tail on a mixed pattern.

Top module: `scan_rotate_seq`

## Requirements
- R1: After reset the block is idle: busy_o=0, func_clk_en_o=1, scan_en_o=0, done_o=0, mode_o=0 and every ring entry reads 0.
- R2: start_i is acted on only while idle. A start seen while busy_o=1 has no effect, so one request gives exactly one done pulse.
- R3: A sequence holds busy_o high for exactly K+5 cycles, where K is the shift count. scan_en_o is high for K consecutive cycles that begin on the fourth busy cycle.
- R4: With wrong_cnt_i=0 at start, K equals the ring length N (default 8), and every entry reads back its value from before the start.
- R5: With wrong_cnt_i=1 at start, K is N-WRONG_OFS (default 7). Each shift moves entry i-1 into entry i, and entry N-1 wraps into entry 0. Entry i afterwards holds the old entry (i+WRONG_OFS) mod N.
- R6: While scan_en_o=1, mode_o reads all ones. After the sequence, mode_o holds the value it had before start.
- R7: A register-file write (wr_en_i) or mode write (mode_we_i) takes effect on the next clock edge only while busy_o=0. Writes presented while busy_o=1 are dropped.
- R8: scan_out_o presents ring entry N-1. During the shift cycles it changes value at least once when the ring holds a mixed pattern, and it never changes when all entries are equal. act_err_o reports 0 in both cases.
- R9: done_o is high for exactly one cycle: the first idle cycle after busy_o falls. In that same cycle match_o is 1 if and only if the ring equals its contents from before the shift, and match_o holds that value until the next done.
- R10: func_clk_en_o is the inverse of busy_o in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a rotation test (used only when idle) |
| wrong_cnt_i | input | 1 | Sampled with start: use the shortened shift count |
| wr_en_i | input | 1 | Functional register-file write enable |
| wr_addr_i | input | $clog2(N) | Write entry index |
| wr_data_i | input | W | Write data |
| mode_we_i | input | 1 | Functional mode register write enable |
| mode_data_i | input | MODE_W | Mode write data |
| rd_addr_i | input | $clog2(N) | Read entry index |
| rd_data_o | output | W | Entry contents at rd_addr_i (combinational) |
| mode_o | output | MODE_W | Current mode register |
| func_clk_en_o | output | 1 | Functional update enable |
| scan_en_o | output | 1 | High during each shift cycle |
| scan_out_o | output | W | Tail of the ring (entry N-1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| match_o | output | 1 | Ring equal before and after, valid with done |
| act_err_o | output | 1 | Tail never moved on a mixed pattern, valid with done |

## Verification
The hardest situation to reach is a functional request that lands while the sequence is running. It may be a write, a mode change or a second start, arriving in the freeze cycles or the shift cycles. None of these can be seen directly at the ports, because their only trace would be a corrupted entry or an extra pulse later on. The stimulus keeps writes, mode writes and start driven on every busy cycle of a run. It then reads back every entry and the mode register after done, and counts done pulses. The wrong-count run uses a pattern with all-distinct entries, so that a shortened rotation shows up as a known one-place shift of the contents.

// File: rtl/scan_rot_pkg.sv
package scan_rot_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_PAUSE   = 3'd1,
        ST_SAVE    = 3'd2,
        ST_ENTER   = 3'd3,
        ST_SHIFT   = 3'd4,
        ST_RESTORE = 3'd5,
        ST_RESUME  = 3'd6
    } seq_state_e;

    // Strobes from the sequencer to the datapath
    typedef struct packed {
        logic busy;
        logic func_en;
        logic shift;
        logic save;
        logic enter;
        logic restore;
        logic finish;
    } seq_ctl_t;

    // Width of a counter that must reach n inclusive
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_rot_pkg::*;
#(
    parameter int unsigned N         = 8,
    parameter int unsigned WRONG_OFS = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     wrong_cnt_i,
    output seq_ctl_t ctl_o
);
    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] FULL_CNT  = CW'(N);
    localparam logic [CW-1:0] SHORT_CNT = CW'(N - WRONG_OFS);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] target_q;
    logic          last_shift;

    assign last_shift = (cnt_q == target_q - CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (start_i) state_d = ST_PAUSE;
            ST_PAUSE:   state_d = ST_SAVE;
            ST_SAVE:    state_d = ST_ENTER;
            ST_ENTER:   state_d = ST_SHIFT;
            ST_SHIFT:   if (last_shift) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_RESUME;
            ST_RESUME:  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            target_q <= FULL_CNT;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && start_i)
                target_q <= wrong_cnt_i ? SHORT_CNT : FULL_CNT;
            if (state_q == ST_ENTER)
                cnt_q <= '0;
            else if (state_q == ST_SHIFT)
                cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        ctl_o         = '0;
        ctl_o.busy    = (state_q != ST_RUN);
        ctl_o.func_en = (state_q == ST_RUN);
        ctl_o.shift   = (state_q == ST_SHIFT);
        ctl_o.save    = (state_q == ST_SAVE);
        ctl_o.enter   = (state_q == ST_ENTER);
        ctl_o.restore = (state_q == ST_RESTORE);
        ctl_o.finish  = (state_q == ST_RESUME);
    end

endmodule

// File: rtl/scan_ring.sv
module scan_ring #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 8,
    parameter int unsigned AW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_i,
    input  logic              snap_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [W-1:0]      rd_data_o,
    output logic [N-1:0][W-1:0] ring_o,
    output logic [W-1:0]      scan_out_o,
    output logic              match_o,
    output logic              mixed_o
);
    logic [N-1:0][W-1:0] ring_q;
    logic [N-1:0][W-1:0] snap_q;

    // Loopback: the tail feeds the head while shifting
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_elem
            logic [W-1:0] shift_src;
            if (gi == 0) begin : g_head
                assign shift_src = ring_q[N-1];
            end else begin : g_body
                assign shift_src = ring_q[gi-1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ring_q[gi] <= '0;
                end else if (shift_i) begin
                    ring_q[gi] <= shift_src;
                end else if (wr_en_i && wr_addr_i == AW'(gi)) begin
                    ring_q[gi] <= wr_data_i;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         snap_q <= '0;
        else if (snap_i) snap_q <= ring_q;
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N; i++)
            if (rd_addr_i == AW'(i)) rd_data_o = ring_q[i];
    end

    always_comb begin
        mixed_o = 1'b0;
        for (int i = 1; i < N; i++)
            if (snap_q[i] != snap_q[0]) mixed_o = 1'b1;
    end

    assign match_o    = (ring_q == snap_q);
    assign scan_out_o = ring_q[N-1];
    assign ring_o     = ring_q;

endmodule

// File: rtl/scan_act_mon.sv
module scan_act_mon
    import scan_rot_pkg::*;
#(
    parameter int unsigned N = 8,
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic [W-1:0] scan_out_i,
    output logic         active_o
);
    localparam int unsigned CW = cnt_width(N);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [W-1:0]  prev_q;
    logic [CW-1:0] trans_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            trans_q <= '0;
        end else if (clear_i) begin
            prev_q  <= scan_out_i;
            trans_q <= '0;
        end else if (shift_i) begin
            prev_q <= scan_out_i;
            if (scan_out_i != prev_q && trans_q != CNT_MAX)
                trans_q <= trans_q + CW'(1);
        end
    end

    assign active_o = (trans_q != '0);

endmodule

// File: rtl/scan_rotate_seq.sv
module scan_rotate_seq
    import scan_rot_pkg::*;
#(
    parameter int unsigned N         = 8,
    parameter int unsigned W         = 8,
    parameter int unsigned MODE_W    = 4,
    parameter int unsigned WRONG_OFS = 1,
    localparam int unsigned AW       = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wrong_cnt_i,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic              mode_we_i,
    input  logic [MODE_W-1:0] mode_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [W-1:0]      rd_data_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              func_clk_en_o,
    output logic              scan_en_o,
    output logic [W-1:0]      scan_out_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              match_o,
    output logic              act_err_o
);
    localparam logic [MODE_W-1:0] SCAN_MODE = '1;

    seq_ctl_t            ctl;
    logic [N-1:0][W-1:0] ring_q;
    logic                ring_match;
    logic                ring_mixed;
    logic                tail_active;
    logic [MODE_W-1:0]   mode_q;
    logic [MODE_W-1:0]   mode_saved_q;
    logic                done_q;
    logic                match_q;
    logic                act_err_q;

    scan_seq_fsm #(
        .N         (N),
        .WRONG_OFS (WRONG_OFS)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .wrong_cnt_i (wrong_cnt_i),
        .ctl_o       (ctl)
    );

    scan_ring #(
        .N  (N),
        .W  (W),
        .AW (AW)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .shift_i    (ctl.shift),
        .snap_i     (ctl.save),
        .wr_en_i    (wr_en_i & ctl.func_en),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .ring_o     (ring_q),
        .scan_out_o (scan_out_o),
        .match_o    (ring_match),
        .mixed_o    (ring_mixed)
    );

    scan_act_mon #(
        .N (N),
        .W (W)
    ) u_mon (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (ctl.enter),
        .shift_i    (ctl.shift),
        .scan_out_i (scan_out_o),
        .active_o   (tail_active)
    );

    // Mode register: functional writes, forced to scan code, restored after
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= '0;
            mode_saved_q <= '0;
        end else begin
            if (ctl.save)
                mode_saved_q <= mode_q;
            if (ctl.func_en && mode_we_i)
                mode_q <= mode_data_i;
            else if (ctl.enter)
                mode_q <= SCAN_MODE;
            else if (ctl.restore)
                mode_q <= mode_saved_q;
        end
    end

    // Completion reporting
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            match_q   <= 1'b0;
            act_err_q <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            if (ctl.finish) begin
                match_q   <= ring_match;
                act_err_q <= ring_mixed & ~tail_active;
            end
        end
    end

    assign mode_o        = mode_q;
    assign func_clk_en_o = ctl.func_en;
    assign scan_en_o     = ctl.shift;
    assign busy_o        = ctl.busy;
    assign done_o        = done_q;
    assign match_o       = match_q;
    assign act_err_o     = act_err_q;

endmodule

// File: rtl/scan_rotate_seq_chk.sv
module scan_rotate_seq_chk #(
    parameter int unsigned N      = 8,
    parameter int unsigned W      = 8,
    parameter int unsigned MODE_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                busy_o,
    input logic                func_clk_en_o,
    input logic                scan_en_o,
    input logic                done_o,
    input logic [MODE_W-1:0]   mode_o,
    input logic [N-1:0][W-1:0] ring_q
);
    // R10
    clk_en_busy_chk: assert property (@(posedge clk) disable iff (rst)
        func_clk_en_o != busy_o);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6
    scan_mode_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en_o |-> (mode_o == {MODE_W{1'b1}}));

    // R3
    shift_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en_o |-> busy_o);

    // R3
    shift_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scan_en_o) |-> ($past(busy_o) && $past(busy_o, 2) && $past(busy_o, 3)));

    // R7
    frozen_ring_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !scan_en_o) |=> $stable(ring_q));

endmodule

bind scan_rotate_seq scan_rotate_seq_chk #(
    .N      (N),
    .W      (W),
    .MODE_W (MODE_W)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .busy_o        (busy_o),
    .func_clk_en_o (func_clk_en_o),
    .scan_en_o     (scan_en_o),
    .done_o        (done_o),
    .mode_o        (mode_o),
    .ring_q        (ring_q)
);

// File: tb/scan_rotate_seq_test.sv
module scan_rotate_seq_test;
    localparam int N      = 8;
    localparam int W      = 8;
    localparam int MODE_W = 4;
    localparam int OFS    = 1;
    localparam int AW     = $clog2(N);

    logic              clk = 1'b0;
    logic              rst;
    logic              start_i, wrong_cnt_i, wr_en_i, mode_we_i;
    logic [AW-1:0]     wr_addr_i, rd_addr_i;
    logic [W-1:0]      wr_data_i;
    logic [MODE_W-1:0] mode_data_i;
    logic [W-1:0]      rd_data_o, scan_out_o;
    logic [MODE_W-1:0] mode_o;
    logic              func_clk_en_o, scan_en_o, busy_o, done_o, match_o, act_err_o;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] exp_q [N];
    logic [MODE_W-1:0] exp_mode;

    // run statistics
    int busy_cyc, scan_cyc, trans, mode_bad, done_cnt, clk_bad, first_scan;

    always #10 clk = ~clk;

    scan_rotate_seq #(.N(N), .W(W), .MODE_W(MODE_W), .WRONG_OFS(OFS)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .wrong_cnt_i(wrong_cnt_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .mode_we_i(mode_we_i), .mode_data_i(mode_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .mode_o(mode_o), .func_clk_en_o(func_clk_en_o),
        .scan_en_o(scan_en_o), .scan_out_o(scan_out_o), .busy_o(busy_o),
        .done_o(done_o), .match_o(match_o), .act_err_o(act_err_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_ring(input string req);
        int bad = 0;
        for (int i = 0; i < N; i++) begin
            rd_addr_i = AW'(i);
            #1;
            if (rd_data_o !== exp_q[i]) begin
                bad++;
                $display("FAIL %s entry %0d: actual=%0h expected=%0h", req, i, rd_data_o, exp_q[i]);
            end
        end
        checks++;
        if (bad != 0) failures++;
    endtask

    task automatic write_entry(input int idx, input logic [W-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = AW'(idx); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        exp_q[idx] = d;
    endtask

    task automatic write_mode(input logic [MODE_W-1:0] m);
        @(negedge clk);
        mode_we_i = 1'b1; mode_data_i = m;
        @(negedge clk);
        mode_we_i = 1'b0;
        exp_mode = m;
    endtask

    // Runs one sequence, with intruding writes/starts on every busy cycle
    task automatic run_seq(input logic wrong, input logic hold_start);
        logic [W-1:0] prev;
        logic have_prev = 1'b0;
        busy_cyc = 0; scan_cyc = 0; trans = 0; mode_bad = 0; done_cnt = 0;
        clk_bad = 0; first_scan = -1;
        @(negedge clk);
        start_i = 1'b1; wrong_cnt_i = wrong;
        @(negedge clk);
        if (!hold_start) start_i = 1'b0;
        wrong_cnt_i = 1'b0;
        while (busy_o) begin
            busy_cyc++;
            if (func_clk_en_o == busy_o) clk_bad++;
            if (done_o) done_cnt++;
            if (scan_en_o) begin
                if (first_scan < 0) first_scan = busy_cyc;
                scan_cyc++;
                if (mode_o !== '1) mode_bad++;
                if (have_prev && scan_out_o != prev) trans++;
                prev = scan_out_o; have_prev = 1'b1;
            end
            wr_en_i = 1'b1; wr_addr_i = AW'(busy_cyc % N); wr_data_i = 8'hEE;
            mode_we_i = 1'b1; mode_data_i = 4'h9;
            @(negedge clk);
            if (busy_cyc > 1000) break;
        end
        start_i = 1'b0; wr_en_i = 1'b0; mode_we_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "busy", busy_o, 0);
        check("R1", "func_clk_en", func_clk_en_o, 1);
        check("R1", "scan_en", scan_en_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "mode", mode_o, 0);
        for (int i = 0; i < N; i++) exp_q[i] = '0;
        check_ring("R1");
    endtask

    task automatic t_functional_writes;
        for (int i = 0; i < N; i++) write_entry(i, W'(8'h11 * (i + 1)));
        check_ring("R7");
        write_mode(4'h5);
        check("R7", "mode write in run", mode_o, 4'h5);
    endtask

    task automatic t_normal_rotation;
        run_seq(1'b0, 1'b0);
        check("R3", "busy cycles", busy_cyc, N + 5);
        check("R3", "shift cycles", scan_cyc, N);
        check("R3", "first shift cycle", first_scan, 4);
        check("R10", "clk enable vs busy", clk_bad, 0);
        check("R6", "mode during shift", mode_bad, 0);
        check("R8", "tail moved on mixed ring", (trans > 0) ? 1 : 0, 1);
        check("R9", "done at end", done_o, 1);
        check("R9", "done during busy", done_cnt, 0);
        check("R9", "match normal", match_o, 1);
        check("R8", "act_err mixed", act_err_o, 0);
        check("R6", "mode restored", mode_o, exp_mode);
        check_ring("R4");
        @(negedge clk);
        check("R9", "done one cycle", done_o, 0);
        check("R9", "match held", match_o, 1);
        check_ring("R7");
    endtask

    task automatic t_wrong_rotation;
        logic [W-1:0] old_q [N];
        for (int i = 0; i < N; i++) old_q[i] = exp_q[i];
        run_seq(1'b1, 1'b0);
        check("R5", "busy cycles", busy_cyc, N - OFS + 5);
        check("R5", "shift cycles", scan_cyc, N - OFS);
        check("R5", "done", done_o, 1);
        check("R5", "match must clear", match_o, 0);
        for (int i = 0; i < N; i++) exp_q[i] = old_q[(i + OFS) % N];
        check_ring("R5");
    endtask

    task automatic t_start_while_busy;
        int extra = 0;
        run_seq(1'b0, 1'b1);
        check("R2", "busy cycles with held start", busy_cyc, N + 5);
        check("R2", "done", done_o, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy_o || done_o) extra++;
        end
        check("R2", "no second sequence", extra, 0);
        check_ring("R2");
        check("R7", "mode writes dropped while busy", mode_o, exp_mode);
    endtask

    task automatic t_uniform;
        for (int i = 0; i < N; i++) write_entry(i, 8'h3C);
        run_seq(1'b0, 1'b0);
        check("R8", "tail stable on uniform ring", trans, 0);
        check("R8", "act_err uniform", act_err_o, 0);
        check("R9", "match uniform", match_o, 1);
        check_ring("R4");
    endtask

    initial begin
        rst = 1'b1; start_i = 0; wrong_cnt_i = 0; wr_en_i = 0; mode_we_i = 0;
        wr_addr_i = '0; wr_data_i = '0; mode_data_i = '0; rd_addr_i = '0;
        exp_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_functional_writes();
        t_normal_rotation();
        t_wrong_rotation();
        t_start_while_busy();
        t_uniform();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule